// File: doc/BRIEF.md
# Global-Clock Flip-Flop Emulator

This block stands in for one edge-triggered register, or for a transparent latch, in a design that runs on a single fast sampling clock. The emulated clock, data, latch enable and asynchronous controls are all ordinary inputs. Every global tick samples them. A clock edge of the emulated register is found by comparing the emulated clock against its own sample from the tick before. The output is formed combinationally from the current inputs and from one-tick history registers.

Parameters select the data width, the mode (plain register, register with asynchronous reset, register with per-bit set and clear, or latch), the active level of every control, the clock edge, the reset value and the initial value. Each asynchronous control, including the latch enable, is widened by one tick. A pulse that lasts a single tick therefore still acts on the output during that tick and during the tick that follows.

Top module: `gclk_ff_emu`

## Requirements
- R1: While `rst_n` is low, every history register holds its initial value: data and output history hold INIT_VAL, control history holds the inactive level, and clock history holds the active clock level. With no control effective and no edge, `q` equals INIT_VAL.
- R2: An edge is seen when `emu_clk` is 1 now and was 0 on the previous tick (CLK_RISE=1), or is 0 now and was 1 on the previous tick (CLK_RISE=0). A clock already at its active level on the first tick after reset produces no edge.
- R3: In a clocked mode, on a tick with an edge, `q` equals the `emu_d` value sampled on the previous tick, and it does so in that same tick.
- R4: In a clocked mode, on a tick with no edge and no effective control, `q` equals its value from the previous tick.
- R5: In latch mode, `q` equals the live `emu_d` while the enable is effective, and holds its previous-tick value otherwise.
- R6: A control is effective on a tick when it is at its active level on that tick or on the previous tick. The active level is 1 when the matching *_HIGH parameter is 1, and 0 otherwise.
- R7: In asynchronous-reset mode, `q` equals RST_VAL on every tick where the reset is effective, even when an edge occurs on that tick.
- R8: In set/clear mode, each bit of `q` is (clocked value OR effective set) AND NOT effective clear. Clear therefore wins over set on the same bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| emu_clk | input | 1 | Emulated clock, sampled as data |
| emu_d | input | WIDTH | Emulated data input |
| emu_en | input | 1 | Latch enable (latch mode) |
| emu_arst | input | 1 | Emulated asynchronous reset |
| emu_set | input | WIDTH | Per-bit emulated asynchronous set |
| emu_clr | input | WIDTH | Per-bit emulated asynchronous clear |
| q | output | WIDTH | Emulated register output |

## Verification
Two functions can act in the same tick. The first pair is an emulated clock edge together with an effective asynchronous reset. The bench drives a rising emulated edge in the same tick as a one-tick reset pulse, and expects RST_VAL in that tick and in the stretched tick after it. The second pair is set and clear on the same bit. The bench drives overlapping set and clear masks and expects every cleared bit to read 0. Random runs also let edges, stretched pulses and latch enables collide freely, and a bench model built from the requirements judges each of those ticks.

// File: rtl/gffe_pkg.sv
package gffe_pkg;
  typedef enum logic [1:0] {
    GFFE_PLAIN  = 2'd0,
    GFFE_ARST   = 2'd1,
    GFFE_SETCLR = 2'd2,
    GFFE_LATCH  = 2'd3
  } gffe_mode_e;
endpackage

// File: rtl/gffe_stretch.sv
// Widens an asynchronous control by one global tick; output is active-high.
module gffe_stretch #(
  parameter int WIDTH    = 1,
  parameter bit ACT_HIGH = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] eff
);
  localparam logic [WIDTH-1:0] IDLE = ACT_HIGH ? '0 : '1;

  logic [WIDTH-1:0] past_q, past_d;
  logic [WIDTH-1:0] raw_act;
  logic             armed;

  always_comb past_d = raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      past_q <= IDLE;
      armed  <= 1'b0;
    end else begin
      past_q <= past_d;
      armed  <= 1'b1;
    end
  end

  generate
    if (ACT_HIGH) begin : g_high
      assign raw_act = raw;
      assign eff     = raw | past_q;
    end else begin : g_low
      assign raw_act = ~raw;
      assign eff     = ~(raw & past_q);
    end
  endgenerate

  // R6: a control active on the previous tick is still effective now
  p_pulse_stretch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> ((eff & $past(raw_act)) == $past(raw_act)));
endmodule

// File: rtl/gffe_edge.sv
// Finds an emulated clock edge from the current and previous samples.
module gffe_edge #(
  parameter bit CLK_RISE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic emu_clk,
  output logic hit
);
  localparam logic [1:0] PAT = CLK_RISE ? 2'b10 : 2'b01;

  logic hist_q, hist_d;
  logic armed;

  always_comb hist_d = emu_clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= CLK_RISE;
      armed  <= 1'b0;
    end else begin
      hist_q <= hist_d;
      armed  <= 1'b1;
    end
  end

  assign hit = ({emu_clk, hist_q} == PAT);

  // R2: a detected edge means the clock moved to its active level since last tick
  p_edge_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && hit) |-> ((emu_clk == CLK_RISE) && ($past(emu_clk) != CLK_RISE)));
endmodule

// File: rtl/gclk_ff_emu.sv
module gclk_ff_emu
  import gffe_pkg::*;
#(
  parameter int               WIDTH     = 8,
  parameter gffe_mode_e       MODE      = GFFE_ARST,
  parameter bit               CLK_RISE  = 1'b1,
  parameter bit               ARST_HIGH = 1'b0,
  parameter bit               SET_HIGH  = 1'b1,
  parameter bit               CLR_HIGH  = 1'b1,
  parameter bit               EN_HIGH   = 1'b1,
  parameter logic [WIDTH-1:0] RST_VAL   = '0,
  parameter logic [WIDTH-1:0] INIT_VAL  = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             emu_clk,
  input  logic [WIDTH-1:0] emu_d,
  input  logic             emu_en,
  input  logic             emu_arst,
  input  logic [WIDTH-1:0] emu_set,
  input  logic [WIDTH-1:0] emu_clr,
  output logic [WIDTH-1:0] q
);
  logic             hit;
  logic             arst_eff, en_eff;
  logic [WIDTH-1:0] set_eff, clr_eff;
  logic [WIDTH-1:0] d_hist_q, d_hist_d;
  logic [WIDTH-1:0] q_hist_q, q_hist_d;
  logic [WIDTH-1:0] clocked, q_n;
  logic             armed;

  gffe_edge #(.CLK_RISE(CLK_RISE)) u_edge (
    .clk(clk), .rst_n(rst_n), .emu_clk(emu_clk), .hit(hit)
  );

  gffe_stretch #(.WIDTH(1), .ACT_HIGH(ARST_HIGH)) u_arst (
    .clk(clk), .rst_n(rst_n), .raw(emu_arst), .eff(arst_eff)
  );

  gffe_stretch #(.WIDTH(1), .ACT_HIGH(EN_HIGH)) u_en (
    .clk(clk), .rst_n(rst_n), .raw(emu_en), .eff(en_eff)
  );

  gffe_stretch #(.WIDTH(WIDTH), .ACT_HIGH(SET_HIGH)) u_set (
    .clk(clk), .rst_n(rst_n), .raw(emu_set), .eff(set_eff)
  );

  gffe_stretch #(.WIDTH(WIDTH), .ACT_HIGH(CLR_HIGH)) u_clr (
    .clk(clk), .rst_n(rst_n), .raw(emu_clr), .eff(clr_eff)
  );

  // history next-state
  always_comb begin
    d_hist_d = emu_d;
    q_hist_d = q_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_hist_q <= INIT_VAL;
      q_hist_q <= INIT_VAL;
      armed    <= 1'b0;
    end else begin
      d_hist_q <= d_hist_d;
      q_hist_q <= q_hist_d;
      armed    <= 1'b1;
    end
  end

  // output composition
  always_comb begin
    clocked = hit ? d_hist_q : q_hist_q;
    case (MODE)
      GFFE_PLAIN:  q_n = clocked;
      GFFE_ARST:   q_n = arst_eff ? RST_VAL : clocked;
      GFFE_SETCLR: q_n = (clocked | set_eff) & ~clr_eff;
      GFFE_LATCH:  q_n = en_eff ? emu_d : q_hist_q;
      default:     q_n = clocked;
    endcase
  end

  assign q = q_n;

  // R3: an edge outputs the data sampled one tick earlier
  p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && hit && (MODE == GFFE_PLAIN || (MODE == GFFE_ARST && !arst_eff)))
      |-> (q == $past(emu_d)));

  // R4: no edge and no effective control keeps the previous output
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !hit && (MODE == GFFE_PLAIN || (MODE == GFFE_ARST && !arst_eff)))
      |-> (q == $past(q)));

  // R5: effective latch enable makes the output transparent
  p_latch_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (MODE == GFFE_LATCH && en_eff) |-> (q == emu_d));

  // R7: effective reset overrides any clocked value
  p_reset_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (MODE == GFFE_ARST && arst_eff) |-> (q == RST_VAL));

  // R8: a cleared bit never reads 1
  p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (MODE == GFFE_SETCLR) |-> ((q & clr_eff) == '0));
endmodule

// File: tb/test_gclk_ff_emu.sv
`timescale 1ns/1ps
module test_gclk_ff_emu;
  import gffe_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       e_clk;
  logic [7:0] e_d;
  logic       a_arstn;
  logic [7:0] b_set, b_clrn;
  logic       c_en;
  logic [7:0] qA, qB, qC;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // model history
  logic       mA_clkp, mB_clkp;
  logic [7:0] mA_dp, mB_dp, mA_q, mB_q, mC_q;
  logic       m_arstp, m_enp;
  logic [7:0] m_setp, m_clrp;

  always #10 clk = ~clk;

  // A: rising edge, active-low async reset
  gclk_ff_emu #(.WIDTH(8), .MODE(GFFE_ARST), .CLK_RISE(1'b1), .ARST_HIGH(1'b0),
                .RST_VAL(8'hA5), .INIT_VAL(8'h3C)) i_gclk_ff_emu (
    .clk(clk), .rst_n(rst_n), .emu_clk(e_clk), .emu_d(e_d), .emu_en(1'b0),
    .emu_arst(a_arstn), .emu_set(8'h00), .emu_clr(8'h00), .q(qA));

  // B: falling edge, set active-high, clear active-low
  gclk_ff_emu #(.WIDTH(8), .MODE(GFFE_SETCLR), .CLK_RISE(1'b0), .SET_HIGH(1'b1),
                .CLR_HIGH(1'b0), .INIT_VAL(8'h00)) i_gclk_ff_emu_sc (
    .clk(clk), .rst_n(rst_n), .emu_clk(e_clk), .emu_d(e_d), .emu_en(1'b0),
    .emu_arst(1'b1), .emu_set(b_set), .emu_clr(b_clrn), .q(qB));

  // C: latch, enable active-high
  gclk_ff_emu #(.WIDTH(8), .MODE(GFFE_LATCH), .EN_HIGH(1'b1),
                .INIT_VAL(8'h81)) i_gclk_ff_emu_lat (
    .clk(clk), .rst_n(rst_n), .emu_clk(e_clk), .emu_d(e_d), .emu_en(c_en),
    .emu_arst(1'b1), .emu_set(8'h00), .emu_clr(8'h00), .q(qC));

  function automatic logic [7:0] f_arst(logic c, logic cp, logic [7:0] dp,
                                        logic [7:0] qp, logic rn, logic rnp);
    logic [7:0] v;
    v = (c && !cp) ? dp : qp;
    return (!(rn && rnp)) ? 8'hA5 : v;
  endfunction

  function automatic logic [7:0] f_setclr(logic c, logic cp, logic [7:0] dp,
                                          logic [7:0] qp, logic [7:0] s,
                                          logic [7:0] sp, logic [7:0] cn,
                                          logic [7:0] cnp);
    logic [7:0] v;
    v = (!c && cp) ? dp : qp;
    return (v | s | sp) & (cn & cnp);
  endfunction

  function automatic logic [7:0] f_latch(logic en, logic enp, logic [7:0] d,
                                         logic [7:0] qp);
    return (en || enp) ? d : qp;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    mA_clkp = 1'b1; mB_clkp = 1'b0;
    mA_dp = 8'h3C; mB_dp = 8'h00;
    mA_q = 8'h3C; mB_q = 8'h00; mC_q = 8'h81;
    m_arstp = 1'b1; m_setp = 8'h00; m_clrp = 8'hFF; m_enp = 1'b0;
  endtask

  task automatic step(logic c, logic [7:0] d, logic rn, logic [7:0] s,
                      logic [7:0] cn, logic en, string ta, string tb, string tc);
    logic [7:0] eA, eB, eC;
    @(negedge clk);
    e_clk = c; e_d = d; a_arstn = rn; b_set = s; b_clrn = cn; c_en = en;
    #2;
    eA = f_arst(c, mA_clkp, mA_dp, mA_q, rn, m_arstp);
    eB = f_setclr(c, mB_clkp, mB_dp, mB_q, s, m_setp, cn, m_clrp);
    eC = f_latch(en, m_enp, d, mC_q);
    check(ta, qA, eA);
    check(tb, qB, eB);
    check(tc, qC, eC);
    mA_clkp = c; mB_clkp = c; mA_dp = d; mB_dp = d;
    mA_q = eA; mB_q = eB; mC_q = eC;
    m_arstp = rn; m_setp = s; m_clrp = cn; m_enp = en;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic       c;
    logic [7:0] d, s, cn;
    logic       rn, en;
    int         hold;
    void'($urandom(32'd2024));
    rst_n = 1'b0;
    e_clk = 1'b1; e_d = 8'h00; a_arstn = 1'b1; b_set = 8'h00; b_clrn = 8'hFF; c_en = 1'b0;
    model_reset();
    repeat (3) @(posedge clk);

    // R1 reset state; R2 clock already active at reset shows no edge
    step(1'b1, 8'h00, 1'b1, 8'h00, 8'hFF, 1'b0, "R1 A", "R1 B", "R1 C");
    check("R1 A init", qA, 8'h3C);
    check("R2 A no first edge", qA, 8'h3C);
    check("R1 C init", qC, 8'h81);
    rst_n = 1'b1;

    // R3/R2: rising edge on A, falling edge on B
    step(1'b0, 8'h55, 1'b1, 8'h00, 8'hFF, 1'b0, "R2 A", "R2 B", "R5 C");
    check("R2 B falling capture", qB, 8'h00);
    step(1'b1, 8'hAA, 1'b1, 8'h00, 8'hFF, 1'b0, "R3 A", "R4 B", "R5 C");
    check("R3 A captures previous data", qA, 8'h55);
    step(1'b1, 8'h0F, 1'b1, 8'h00, 8'hFF, 1'b0, "R4 A", "R4 B", "R5 C");
    check("R4 A hold", qA, 8'h55);
    step(1'b0, 8'h0F, 1'b1, 8'h00, 8'hFF, 1'b0, "R4 A", "R3 B", "R5 C");
    check("R3 B falling capture", qB, 8'h0F);

    // R7: edge and one-tick reset pulse in the same tick
    step(1'b1, 8'h77, 1'b0, 8'h00, 8'hFF, 1'b0, "R7 A", "R4 B", "R5 C");
    check("R7 A reset over edge", qA, 8'hA5);
    step(1'b1, 8'h77, 1'b1, 8'h00, 8'hFF, 1'b0, "R6 A", "R4 B", "R5 C");
    check("R6 A reset stretched", qA, 8'hA5);
    step(1'b1, 8'h77, 1'b1, 8'h00, 8'hFF, 1'b0, "R4 A", "R4 B", "R5 C");
    check("R4 A hold after reset", qA, 8'hA5);

    // R8: set and clear on the same bits
    step(1'b1, 8'h00, 1'b1, 8'hFF, 8'h0F, 1'b0, "R4 A", "R8 B", "R5 C");
    check("R8 B clear wins", qB, 8'h0F);
    step(1'b1, 8'h00, 1'b1, 8'h00, 8'hFF, 1'b0, "R4 A", "R6 B", "R5 C");
    check("R6 B set and clear stretched", qB, 8'h0F);
    step(1'b1, 8'h00, 1'b1, 8'hF0, 8'hFF, 1'b0, "R4 A", "R8 B", "R5 C");
    check("R8 B set only", qB, 8'hFF);

    // R5 latch transparency, stretch and hold
    step(1'b1, 8'h3E, 1'b1, 8'h00, 8'hFF, 1'b1, "R4 A", "R8 B", "R5 C");
    check("R5 C transparent", qC, 8'h3E);
    step(1'b1, 8'h11, 1'b1, 8'h00, 8'hFF, 1'b0, "R4 A", "R8 B", "R6 C");
    check("R6 C enable stretched", qC, 8'h11);
    step(1'b1, 8'h22, 1'b1, 8'h00, 8'hFF, 1'b0, "R4 A", "R8 B", "R5 C");
    check("R5 C hold", qC, 8'h11);

    // random phase
    c = 1'b1; hold = 0;
    for (int i = 0; i < 3000; i++) begin
      if (hold == 0) begin
        c = ~c;
        hold = $urandom_range(0, 3);
      end else begin
        hold--;
      end
      d  = 8'($urandom());
      rn = ($urandom_range(0, 15) != 0);
      s  = ($urandom_range(0, 7) == 0) ? 8'($urandom()) : 8'h00;
      cn = ($urandom_range(0, 7) == 0) ? 8'($urandom()) : 8'hFF;
      en = ($urandom_range(0, 3) == 0);
      step(c, d, rn, s, cn, en, "R3 A random", "R8 B random", "R5 C random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule